// File: doc/BRIEF.md
# Target-Side Information Transfer Engine

This block runs the target half of the byte-wide, interlocked information transfer on an asynchronous peripheral bus. Once a device has been selected, the surrounding target logic asks for a phase and a byte count. The engine drives the three phase lines and, where the bus direction calls for it, the data lines with an odd parity bit. It then performs one request/acknowledge exchange per byte until the count is used up.

In the initiator-bound direction, bytes are pulled one at a time from a transmit interface. In the target-bound direction, bytes are captured from the bus and presented with a one-cycle valid strobe and a sticky parity error flag. The acknowledge, attention and bus-reset lines arrive asynchronously and are synchronized inside the block. Every interlock delay is a cycle count set by a parameter.

A transfer ends in one of three ways, each signalled by a one-cycle pulse: normal completion after the last byte, a request timeout, or refusal of an illegal request. A bus reset releases every driven line and returns the engine to idle.

Top module: `bus_xfer_target`

## Requirements
- R1: The phase is driven on (msg_o, cd_o, io_o) with these codes: 000 data to target, 001 data to initiator, 010 command, 011 status, 110 message to target, 111 message to initiator. msg_o=1 with cd_o=0 is never driven. A start request carrying code 100 or 101 is refused with a reject_o pulse one cycle later, and the engine stays idle.
- R2: After an accepted start, the phase lines hold the requested code for at least SETTLE_CYC cycles before the first REQ. They do not change until the burst ends.
- R3: Each byte uses four edges in strict order. REQ rises only while the synchronized ACK is low. REQ stays high until ACK is seen high, then falls. The next REQ waits until ACK is seen low again.
- R4: When io_o=1, the byte is driven on db_o with db_oe_o=1 at least DATA_SETUP_CYC cycles before REQ rises. The nine bits {db_o, dbp_o} have an odd number of ones. db_o does not change while REQ is high.
- R5: When io_o=0, the byte on db_i is captured while ACK is seen high and presented on rx_data_o with a one-cycle rx_valid_o. A byte whose nine bits {db_i, dbp_i} have even weight sets par_err_o. The burst still completes. par_err_o stays set until the next accepted start.
- R6: A start with code 110 is accepted only while the synchronized attention line is high. Otherwise it is refused with reject_o.
- R7: If ACK does not change within TIMEOUT_CYC cycles of the REQ edge that awaits it, the engine pulses timeout_o, drops REQ and returns to idle.
- R8: While bus_rst_i is high, no start is accepted. Within SYNC_STAGES+1 cycles of it rising, REQ, the phase lines and the data enable are released and busy_o is low. Reset takes precedence over any other event in the same cycle.
- R9: done_o pulses once after the ACK of the last of count_i bytes falls. A count of zero is refused with reject_o. At most one of done_o, timeout_o and reject_o is high in any cycle.
- R10: tx_pop_o pulses once per byte of an io_o=1 burst, and never in an io_o=0 burst. The byte on tx_data_i is taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a burst, sampled while idle |
| phase_i | input | 3 | Requested phase code {msg, cd, io} |
| count_i | input | CNT_W | Number of bytes in the burst |
| tx_data_i | input | 8 | Next byte to send to the initiator |
| tx_pop_o | output | 1 | tx_data_i is consumed this cycle |
| ack_i | input | 1 | Bus ACK, asynchronous |
| atn_i | input | 1 | Bus attention, asynchronous |
| bus_rst_i | input | 1 | Bus reset line, asynchronous |
| db_i | input | 8 | Data bus from the initiator |
| dbp_i | input | 1 | Parity bit from the initiator |
| req_o | output | 1 | Bus REQ |
| msg_o | output | 1 | Phase line: message |
| cd_o | output | 1 | Phase line: control/data |
| io_o | output | 1 | Phase line: direction, 1 = to initiator |
| db_o | output | 8 | Data bus driven by the target |
| dbp_o | output | 1 | Odd parity of db_o |
| db_oe_o | output | 1 | Data bus output enable |
| rx_data_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | rx_data_o updated this cycle |
| par_err_o | output | 1 | Sticky receive parity error |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | Burst completed |
| timeout_o | output | 1 | Burst aborted on ACK timeout |
| reject_o | output | 1 | Start request refused |

## Verification
Two events can fall in the same cycle: the bus reset arriving and the completion of the final byte. Both inputs pass through identical synchronizers. The bench therefore drops ACK on the last byte and raises the bus reset at the same clock edge, so that both reach the state machine in the same cycle. The result is judged at the ports. No done pulse may appear, and all lines must be released, because reset wins. A second test overlaps a parity error with completion: the bad byte is the last one, and the bench checks that both the done pulse and the sticky error appear.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_LOAD,
    ST_SETUP,
    ST_REQ,
    ST_RACK,
    ST_DONE
  } xfer_state_e;

  localparam logic [2:0] PH_DOUT   = 3'b000;
  localparam logic [2:0] PH_DIN    = 3'b001;
  localparam logic [2:0] PH_CMD    = 3'b010;
  localparam logic [2:0] PH_STAT   = 3'b011;
  localparam logic [2:0] PH_MOUT   = 3'b110;
  localparam logic [2:0] PH_MIN    = 3'b111;

  // parity bit that makes the nine-bit word odd
  function automatic logic odd_par(input logic [7:0] b);
    return ~^b;
  endfunction

  function automatic logic phase_code_ok(input logic [2:0] p);
    return !(p[2] && !p[1]);
  endfunction

endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= stg[g-1];
      end
    end
  end

  assign sync_o = stg[STAGES-1];

endmodule

// File: rtl/xfer_timer.sv
module xfer_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/bus_xfer_target.sv
module bus_xfer_target
  import xfer_pkg::*;
#(
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned SETTLE_CYC     = 10,
  parameter int unsigned DATA_SETUP_CYC = 3,
  parameter int unsigned TIMEOUT_CYC    = 62_500_000,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [2:0]       phase_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [7:0]       tx_data_i,
  output logic             tx_pop_o,
  input  logic             ack_i,
  input  logic             atn_i,
  input  logic             bus_rst_i,
  input  logic [7:0]       db_i,
  input  logic             dbp_i,
  output logic             req_o,
  output logic             msg_o,
  output logic             cd_o,
  output logic             io_o,
  output logic [7:0]       db_o,
  output logic             dbp_o,
  output logic             db_oe_o,
  output logic [7:0]       rx_data_o,
  output logic             rx_valid_o,
  output logic             par_err_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic             reject_o
);

  localparam int unsigned TMR_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMR_W-1:0] SETTLE_V = TMR_W'(SETTLE_CYC);
  localparam logic [TMR_W-1:0] SETUP_V  = TMR_W'(DATA_SETUP_CYC);
  localparam logic [TMR_W-1:0] TMO_V    = TMR_W'(TIMEOUT_CYC);

  logic ack_s, atn_s, rst_s;

  bus_sync #(.W(3), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({ack_i, atn_i, bus_rst_i}),
    .sync_o  ({ack_s, atn_s, rst_s})
  );

  logic             tmr_load;
  logic [TMR_W-1:0] tmr_val;
  logic             tmr_zero;

  xfer_timer #(.W(TMR_W)) i_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  xfer_state_e      st_q, st_d;
  logic [2:0]       phase_q;
  logic [CNT_W-1:0] rem_q;
  logic [7:0]       out_q;
  logic [7:0]       rx_q;
  logic             rx_valid_q, par_err_q, tmo_q, rej_q;
  logic             accept, refuse, pop, cap, tmo, legal;

  assign legal = phase_code_ok(phase_i) && (count_i != '0) &&
                 ((phase_i != PH_MOUT) || atn_s);

  always_comb begin
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = 1'b0;
    refuse   = 1'b0;
    pop      = 1'b0;
    cap      = 1'b0;
    tmo      = 1'b0;
    if (rst_s) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          if (legal) begin
            accept   = 1'b1;
            st_d     = ST_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = SETTLE_V;
          end else begin
            refuse = 1'b1;
          end
        end
        ST_SETTLE: if (tmr_zero) st_d = ST_LOAD;
        ST_LOAD: begin
          pop      = phase_q[0];
          st_d     = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = SETUP_V;
        end
        ST_SETUP: if (tmr_zero) begin
          st_d     = ST_REQ;
          tmr_load = 1'b1;
          tmr_val  = TMO_V;
        end
        ST_REQ: begin
          if (ack_s) begin
            cap      = 1'b1;
            st_d     = ST_RACK;
            tmr_load = 1'b1;
            tmr_val  = TMO_V;
          end else if (tmr_zero) begin
            tmo  = 1'b1;
            st_d = ST_IDLE;
          end
        end
        ST_RACK: begin
          if (!ack_s) begin
            st_d = (rem_q == CNT_W'(1)) ? ST_DONE : ST_LOAD;
          end else if (tmr_zero) begin
            tmo  = 1'b1;
            st_d = ST_IDLE;
          end
        end
        ST_DONE: st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      phase_q    <= '0;
      rem_q      <= '0;
      out_q      <= '0;
      rx_q       <= '0;
      rx_valid_q <= 1'b0;
      par_err_q  <= 1'b0;
      tmo_q      <= 1'b0;
      rej_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      tmo_q      <= tmo;
      rej_q      <= refuse;
      rx_valid_q <= cap && !phase_q[0];
      if (accept) begin
        phase_q   <= phase_i;
        rem_q     <= count_i;
        par_err_q <= 1'b0;
      end
      if (pop) out_q <= tx_data_i;
      if (cap && !phase_q[0]) begin
        rx_q <= db_i;
        if (dbp_i != odd_par(db_i)) par_err_q <= 1'b1;
      end
      if (!rst_s && st_q == ST_RACK && !ack_s) rem_q <= rem_q - CNT_W'(1);
    end
  end

  logic active, drive;
  assign active = (st_q != ST_IDLE);
  assign drive  = phase_q[0] &&
                  (st_q == ST_SETUP || st_q == ST_REQ || st_q == ST_RACK);

  assign {msg_o, cd_o, io_o} = active ? phase_q : 3'b000;
  assign req_o      = (st_q == ST_REQ);
  assign db_oe_o    = drive;
  assign db_o       = drive ? out_q : 8'h00;
  assign dbp_o      = drive ? odd_par(out_q) : 1'b0;
  assign tx_pop_o   = pop;
  assign rx_data_o  = rx_q;
  assign rx_valid_o = rx_valid_q;
  assign par_err_o  = par_err_q;
  assign busy_o     = active;
  assign done_o     = (st_q == ST_DONE);
  assign timeout_o  = tmo_q;
  assign reject_o   = rej_q;

endmodule

// File: rtl/xfer_checker.sv
module xfer_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_o,
  input logic       msg_o,
  input logic       cd_o,
  input logic       io_o,
  input logic [7:0] db_o,
  input logic       dbp_o,
  input logic       db_oe_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       timeout_o,
  input logic       reject_o,
  input logic       ack_s,
  input logic       atn_s,
  input logic       rst_s
);

  p_no_unused_code_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(msg_o && !cd_o));

  p_phase_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable({msg_o, cd_o, io_o}));

  p_req_after_ack_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> !ack_s);

  p_data_driven_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_o && req_o) |-> db_oe_o);

  p_data_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && $past(req_o)) |-> $stable(db_o));

  p_odd_parity_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_oe_o |-> (^{db_o, dbp_o}));

  p_msgout_atn_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(busy_o) && {msg_o, cd_o, io_o} == 3'b110) |-> $past(atn_s));

  p_bus_reset_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_s |=> (!busy_o && !req_o && !db_oe_o));

  p_single_outcome_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, timeout_o, reject_o}));

endmodule

bind bus_xfer_target xfer_checker i_xfer_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_o     (req_o),
  .msg_o     (msg_o),
  .cd_o      (cd_o),
  .io_o      (io_o),
  .db_o      (db_o),
  .dbp_o     (dbp_o),
  .db_oe_o   (db_oe_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .timeout_o (timeout_o),
  .reject_o  (reject_o),
  .ack_s     (ack_s),
  .atn_s     (atn_s),
  .rst_s     (rst_s)
);

// File: tb/test_bus_xfer_target.sv
module test_bus_xfer_target;

  localparam int CNT_W   = 8;
  localparam int SETTLE  = 6;
  localparam int SETUP   = 3;
  localparam int TMO     = 300;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [2:0] phase_i = '0;
  logic [CNT_W-1:0] count_i = '0;
  logic [7:0] tx_data_i;
  logic ack_i = 1'b0, atn_i = 1'b0, bus_rst_i = 1'b0;
  logic [7:0] db_i = '0;
  logic dbp_i = 1'b0;
  logic tx_pop_o, req_o, msg_o, cd_o, io_o, dbp_o, db_oe_o;
  logic [7:0] db_o, rx_data_o;
  logic rx_valid_o, par_err_o, busy_o, done_o, timeout_o, reject_o;

  logic [7:0] tx_base = '0;
  int tx_idx = 0;
  int pop_cnt = 0;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  assign tx_data_i = tx_base + 8'(tx_idx * 37);

  always #2 clk = ~clk;

  bus_xfer_target #(
    .CNT_W(CNT_W), .SETTLE_CYC(SETTLE), .DATA_SETUP_CYC(SETUP),
    .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)
  ) i_bus_xfer_target (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .phase_i(phase_i),
    .count_i(count_i), .tx_data_i(tx_data_i), .tx_pop_o(tx_pop_o),
    .ack_i(ack_i), .atn_i(atn_i), .bus_rst_i(bus_rst_i), .db_i(db_i),
    .dbp_i(dbp_i), .req_o(req_o), .msg_o(msg_o), .cd_o(cd_o), .io_o(io_o),
    .db_o(db_o), .dbp_o(dbp_o), .db_oe_o(db_oe_o), .rx_data_o(rx_data_o),
    .rx_valid_o(rx_valid_o), .par_err_o(par_err_o), .busy_o(busy_o),
    .done_o(done_o), .timeout_o(timeout_o), .reject_o(reject_o)
  );

  always @(negedge clk) if (tx_pop_o) pop_cnt++;

  function automatic logic [7:0] rx_byte(input logic [7:0] base, input int k);
    return base + 8'(k * 11);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic start_req(input logic [2:0] ph, input int n);
    @(negedge clk);
    phase_i = ph; count_i = CNT_W'(n); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  // bad: index of byte sent with wrong parity, -1 for none
  task automatic burst(input logic [2:0] ph, input int n, input int bad);
    int wc, pre, pop0, dly;
    bit stable_ok, order_ok;
    logic [7:0] exp_b, hold, rx_base;
    tx_base = 8'($urandom);
    rx_base = 8'($urandom);
    tx_idx = 0;
    pop0 = pop_cnt;
    stable_ok = 1'b1;
    order_ok = 1'b1;
    start_req(ph, n);
    for (int k = 0; k < n; k++) begin
      wc = 0; pre = 0;
      while (!req_o && wc < 2000) begin
        if (db_oe_o) pre++;
        if ({msg_o, cd_o, io_o} != ph) stable_ok = 1'b0;
        @(negedge clk); wc++;
      end
      chk(req_o, "R3 req rise", 32'(req_o), 1);
      if (k == 0) chk(wc >= SETTLE, "R2 settle before first req", wc, SETTLE);
      chk({msg_o, cd_o, io_o} == ph, "R1 phase code at req", {msg_o, cd_o, io_o}, ph);
      if (ph[0]) begin
        exp_b = tx_base + 8'(k * 37);
        chk(db_oe_o && db_o == exp_b, "R4 data to initiator", db_o, exp_b);
        chk(^{db_o, dbp_o}, "R4 odd parity", {db_o, dbp_o}, 1);
        chk(pre >= SETUP, "R4 data setup before req", pre, SETUP);
      end else begin
        db_i  = rx_byte(rx_base, k);
        dbp_i = (~^db_i) ^ (k == bad);
      end
      dly = $urandom_range(0, 3);
      repeat (dly) begin
        @(negedge clk);
        if (!req_o) order_ok = 1'b0;
      end
      hold = db_o;
      ack_i = 1'b1;
      wc = 0;
      while (req_o && wc < 2000) begin
        if (ph[0] && db_o != hold) stable_ok = 1'b0;
        @(negedge clk); wc++;
      end
      chk(!req_o, "R3 req fall after ack", 32'(req_o), 0);
      if (!ph[0])
        chk(rx_valid_o && rx_data_o == rx_byte(rx_base, k), "R5 received byte",
            {rx_valid_o, rx_data_o}, {1'b1, rx_byte(rx_base, k)});
      dly = $urandom_range(0, 3);
      repeat (dly) begin
        @(negedge clk);
        if (req_o) order_ok = 1'b0;
      end
      ack_i = 1'b0;
      tx_idx++;
    end
    wc = 0;
    while (!done_o && wc < 12) begin @(negedge clk); wc++; end
    chk(done_o, "R9 done after last byte", 32'(done_o), 1);
    chk(stable_ok, "R2 phase and data held across burst", stable_ok, 1);
    chk(order_ok, "R3 four-edge order", order_ok, 1);
    chk(pop_cnt - pop0 == (ph[0] ? n : 0), "R10 pop count", pop_cnt - pop0,
        ph[0] ? n : 0);
    chk(par_err_o == (!ph[0] && bad >= 0 && bad < n), "R5 sticky parity flag",
        par_err_o, (!ph[0] && bad >= 0 && bad < n));
    @(negedge clk);
  endtask

  task automatic expect_reject(input logic [2:0] ph, input int n, input string tag);
    start_req(ph, n);
    chk(reject_o && !busy_o, tag, {reject_o, busy_o}, 2'b10);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!req_o && !busy_o && {msg_o, cd_o, io_o} == 3'b000 && !db_oe_o && !par_err_o,
        "R8 reset state", {req_o, busy_o, msg_o, cd_o, io_o, db_oe_o}, 0);

    // directed: every legal phase except message-out
    burst(3'b000, 3, -1);
    burst(3'b001, 4, -1);
    burst(3'b010, 6, -1);
    burst(3'b011, 1, -1);
    burst(3'b111, 2, -1);

    // R6: message-out with and without attention
    expect_reject(3'b110, 2, "R6 msg-out refused without atn");
    atn_i = 1'b1;
    repeat (4) @(negedge clk);
    burst(3'b110, 2, -1);
    atn_i = 1'b0;
    repeat (4) @(negedge clk);

    // R1 / R9 refusals
    expect_reject(3'b100, 1, "R1 unused code 100 refused");
    expect_reject(3'b101, 1, "R1 unused code 101 refused");
    expect_reject(3'b000, 0, "R9 zero count refused");

    // R5: parity error mid-burst, flag persists, cleared by next start
    burst(3'b000, 4, 1);
    burst(3'b010, 2, 1);  // last byte bad: done and error together
    burst(3'b000, 2, -1);

    // random mix
    for (int r = 0; r < 24; r++) begin
      logic [2:0] ph;
      int n, pick;
      pick = $urandom_range(0, 4);
      ph = (pick == 0) ? 3'b000 : (pick == 1) ? 3'b001 : (pick == 2) ? 3'b010 :
           (pick == 3) ? 3'b011 : 3'b111;
      n = $urandom_range(1, 7);
      burst(ph, n, ($urandom_range(0, 3) == 0) ? $urandom_range(0, n - 1) : -1);
    end

    // R7: no acknowledge
    begin
      int wc;
      start_req(3'b001, 1);
      wc = 0;
      while (!req_o && wc < 100) begin @(negedge clk); wc++; end
      wc = 0;
      while (!timeout_o && wc < TMO + 20) begin @(negedge clk); wc++; end
      chk(timeout_o, "R7 timeout pulse", 32'(timeout_o), 1);
      chk(wc >= TMO, "R7 timeout not early", wc, TMO);
      chk(!req_o && !busy_o, "R7 released after timeout", {req_o, busy_o}, 0);
      @(negedge clk);
    end

    // R8: bus reset in mid-burst
    begin
      int wc;
      start_req(3'b001, 3);
      wc = 0;
      while (!req_o && wc < 100) begin @(negedge clk); wc++; end
      bus_rst_i = 1'b1;
      repeat (3) @(negedge clk);
      chk(!req_o && !busy_o && !db_oe_o && {msg_o, cd_o, io_o} == 3'b000,
          "R8 lines released on bus reset", {req_o, busy_o, db_oe_o, msg_o, cd_o, io_o}, 0);
      start_req(3'b000, 1);
      chk(!busy_o && !reject_o, "R8 start ignored during bus reset", {busy_o, reject_o}, 0);
      bus_rst_i = 1'b0;
      repeat (4) @(negedge clk);
    end

    // R8: bus reset in the same cycle as the final ACK release
    begin
      int wc;
      bit saw_done;
      start_req(3'b000, 2);
      for (int k = 0; k < 2; k++) begin
        wc = 0;
        while (!req_o && wc < 100) begin @(negedge clk); wc++; end
        db_i = 8'h3c; dbp_i = ~^db_i;
        ack_i = 1'b1;
        wc = 0;
        while (req_o && wc < 100) begin @(negedge clk); wc++; end
        ack_i = 1'b0;
        if (k == 1) bus_rst_i = 1'b1;
      end
      saw_done = 1'b0;
      repeat (8) begin @(negedge clk); if (done_o) saw_done = 1'b1; end
      chk(!saw_done, "R8 reset beats completion", saw_done, 0);
      chk(!busy_o && !req_o, "R8 idle after concurrent reset", {busy_o, req_o}, 0);
      bus_rst_i = 1'b0;
      repeat (4) @(negedge clk);
      burst(3'b011, 1, -1);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R3 handshake stalled act=running exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule